// File: doc/BRIEF.md
# Tracking Position Counter

This block is the digital back end of a tracking angle converter. An external analog loop, which drives the angle error to zero, sends it single-step up and down pulses. The block counts them into a natural-binary position word and needs no convert command. Each counted step raises a one-cycle BUSY pulse. A full turn of the count, in either direction, raises a wrap pulse one cycle later. A latched direction flag records which way the last step went.

Two select pins set the resolution to 10, 12, 14 or 16 bits while the block runs. A change of resolution waits until the counter is quiet. An inhibit input freezes the parallel output latch so that a reader can capture a stable word. The counter keeps tracking behind the latch, and inhibit has no effect on the wrap pulse or the direction flag.

A small controller has three named states. ST_IDLE means the last edge did nothing. ST_STEP means the last edge accepted a step, and BUSY is high in this state. ST_RESIZE means the last edge applied a new resolution. From any state, an effective step moves the controller to ST_STEP. With no step, a select value that differs from the current resolution moves it to ST_RESIZE, but only when the current state is not ST_STEP. Every other case moves it to ST_IDLE.

Top module: `trk_pos_counter`

## Requirements
- R1: `res_sel` picks the width: 00 gives 10 bits, 01 gives 12, 10 gives 14 and 11 gives 16. The position sits in the low bits, and every bit above the selected width reads zero.
- R2: An accepted `step_up` adds one to the count and an accepted `step_dn` subtracts one. Both are modulo 2 to the power of the selected width, and `pos_out` shows the new value in the cycle after the accepting edge.
- R3: `busy` is high for exactly the one cycle after each edge that changes the count through a step. When `step_up` and `step_dn` are both high in the same cycle they cancel: the count does not change and no busy pulse appears. A resolution change raises no busy pulse.
- R4: A step up from all ones to zero, or a step down from zero to all ones, raises `wrap`. All ones is measured at the selected width.
- R5: `wrap` is high for one cycle, and that cycle comes one cycle after the busy cycle of the step that caused it.
- R6: `dir_down` is 1 after a down step and 0 after an up step. It changes on the same edge that accepts the reversing step, and it holds its value through cancelled steps and idle cycles.
- R7: While `inhibit` is high, `pos_out` holds its value and the counter keeps counting. On the first edge after `inhibit` falls, `pos_out` loads the current count.
- R8: `inhibit` has no effect on `wrap` or `dir_down`.
- R9: A new resolution is applied only on an edge that has no effective step and follows a cycle in which `busy` was low. When the width shrinks, the count drops the bits above the new width.
- R10: A synchronous reset, `rst` high, clears the count and `pos_out` to zero, sets `dir_down` to 0 (up), drives `busy` and `wrap` low, and loads the resolution from `res_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_up | input | 1 | One-LSB up step request |
| step_dn | input | 1 | One-LSB down step request |
| res_sel | input | 2 | Resolution select (00=10, 01=12, 10=14, 11=16 bits) |
| inhibit | input | 1 | Freezes the output latch while high |
| pos_out | output | POS_W | Latched natural-binary position |
| busy | output | 1 | One-cycle pulse per counted step |
| wrap | output | 1 | One-cycle pulse at a full-turn carry |
| dir_down | output | 1 | Latched direction, 1 = down |

## Verification
A step is driven for one cycle and taken on edge N. From edge N, `pos_out`, `busy` and `dir_down` change together. `wrap` rises at N+1 and falls at N+2. A resolution change requested together with a step shows in `pos_out` only at N+2, and an inhibit release shows on the first edge after it. The bench drives inputs on falling edges and reads outputs on the falling edge after each edge of interest. It therefore checks each result in its exact cycle and also checks the value one cycle before and after it.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_RESIZE = 2'd2
    } trk_state_e;
endpackage

// File: rtl/trk_res_decode.sv
module trk_res_decode #(
    parameter int POS_W = 16
) (
    input  logic [1:0]       sel,
    output logic [POS_W-1:0] mask
);
    localparam int MIN_W = POS_W - 6;

    // Width = MIN_W + 2*sel; mask has that many low ones (R1)
    for (genvar g = 0; g < POS_W; g++) begin : g_bit
        assign mask[g] = (g < (MIN_W + 2 * int'(sel)));
    end
endmodule

// File: rtl/trk_ctrl_fsm.sv
module trk_ctrl_fsm (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_up,
    input  logic       step_dn,
    input  logic [1:0] res_sel,
    output logic [1:0] res_q,
    output logic       busy,
    output logic       step_fire,
    output logic       step_down,
    output logic       res_load
);
    import trk_pkg::*;

    trk_state_e state_q, state_nx;
    logic       fire;

    always_comb begin
        fire = step_up ^ step_dn;
        if (fire)
            state_nx = ST_STEP;
        else if ((res_sel != res_q) && (state_q != ST_STEP))
            state_nx = ST_RESIZE;
        else
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            res_q   <= res_sel;
        end else begin
            state_q <= state_nx;
            if (state_nx == ST_RESIZE)
                res_q <= res_sel;
        end
    end

    always_comb begin
        step_fire = fire;
        step_down = step_dn;
        res_load  = (state_nx == ST_RESIZE);
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_STEP:   busy = 1'b1;
            ST_RESIZE: busy = 1'b0;
            default:   busy = 1'b0;
        endcase
    end

    // R9: resolution only moves after a quiet, non-busy cycle
    assert_res_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (res_q != $past(res_q))) |->
        (!$past(busy) && !$past(step_up ^ step_dn)));
endmodule

// File: rtl/trk_count_path.sv
module trk_count_path #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_fire,
    input  logic             step_down,
    input  logic             res_load,
    input  logic             inhibit,
    input  logic [POS_W-1:0] mask_cur,
    input  logic [POS_W-1:0] mask_new,
    output logic [POS_W-1:0] pos_out,
    output logic             carry_hit
);
    logic [POS_W-1:0] count_q, count_nx, latch_q;

    always_comb begin
        count_nx  = count_q;
        carry_hit = 1'b0;
        if (step_fire) begin
            if (step_down) begin
                count_nx  = (count_q - POS_W'(1)) & mask_cur;
                carry_hit = (count_q == '0);
            end else begin
                count_nx  = (count_q + POS_W'(1)) & mask_cur;
                carry_hit = (count_q == mask_cur);
            end
        end else if (res_load) begin
            count_nx = count_q & mask_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            latch_q <= '0;
        end else begin
            count_q <= count_nx;
            if (!inhibit)
                latch_q <= count_nx;
        end
    end

    assign pos_out = latch_q;

    // R1: no bits above the active width
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (count_q & ~mask_cur) == '0);
    // R2: an accepted step always moves the count
    assert_step_moves_R2: assert property (@(posedge clk) disable iff (rst)
        $past(step_fire && !rst) |-> (count_q != $past(count_q)));
    // R7: the output latch holds under inhibit
    assert_inhibit_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(inhibit) && !$past(rst)) |-> $stable(latch_q));
endmodule

// File: rtl/trk_dir_wrap.sv
module trk_dir_wrap (
    input  logic clk,
    input  logic rst,
    input  logic step_fire,
    input  logic step_down,
    input  logic carry_hit,
    output logic dir_down,
    output logic wrap
);
    logic dir_q, carry_q, wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            carry_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else begin
            if (step_fire)
                dir_q <= step_down;
            carry_q <= step_fire & carry_hit;
            wrap_q  <= carry_q;
        end
    end

    assign dir_down = dir_q;
    assign wrap     = wrap_q;

    // R6: direction only changes on an accepted step
    assert_dir_on_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (dir_q != $past(dir_q))) |-> $past(step_fire));
    // R5: wrap is a single-cycle pulse
    assert_wrap_single_R5: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);
endmodule

// File: rtl/trk_pos_counter.sv
module trk_pos_counter #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [1:0]       res_sel,
    input  logic             inhibit,
    output logic [POS_W-1:0] pos_out,
    output logic             busy,
    output logic             wrap,
    output logic             dir_down
);
    logic [1:0]       res_q;
    logic             step_fire, step_down, res_load, carry_hit;
    logic [POS_W-1:0] mask_cur, mask_new;

    trk_ctrl_fsm u_fsm (
        .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
        .res_sel(res_sel), .res_q(res_q), .busy(busy),
        .step_fire(step_fire), .step_down(step_down), .res_load(res_load)
    );

    trk_res_decode #(.POS_W(POS_W)) u_dec_cur (.sel(res_q),   .mask(mask_cur));
    trk_res_decode #(.POS_W(POS_W)) u_dec_new (.sel(res_sel), .mask(mask_new));

    trk_count_path #(.POS_W(POS_W)) u_count (
        .clk(clk), .rst(rst), .step_fire(step_fire), .step_down(step_down),
        .res_load(res_load), .inhibit(inhibit), .mask_cur(mask_cur),
        .mask_new(mask_new), .pos_out(pos_out), .carry_hit(carry_hit)
    );

    trk_dir_wrap u_dw (
        .clk(clk), .rst(rst), .step_fire(step_fire), .step_down(step_down),
        .carry_hit(carry_hit), .dir_down(dir_down), .wrap(wrap)
    );

    // R5: wrap follows a busy cycle
    assert_wrap_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
        wrap |-> $past(busy));
    // R3: busy is never two-wide without a second step
    assert_busy_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(rst)) |-> $past(step_fire));
endmodule

// File: tb/trk_pos_counter_tb_top.sv
`timescale 1ns/1ps
module trk_pos_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_up = 1'b0, step_dn = 1'b0, inhibit = 1'b0;
    logic [1:0]  res_sel = 2'b11;
    logic [15:0] pos_out;
    logic        busy, wrap, dir_down;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trk_pos_counter #(.POS_W(16)) dut_i (
        .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
        .res_sel(res_sel), .inhibit(inhibit), .pos_out(pos_out),
        .busy(busy), .wrap(wrap), .dir_down(dir_down)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_step(input logic up, input logic dn);
        @(negedge clk);
        step_up = up;
        step_dn = dn;
        @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "pos", int'(pos_out), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "wrap", int'(wrap), 0);
        chk("R10", "dir", int'(dir_down), 0);
    endtask

    task automatic t_updown();
        do_step(1'b1, 1'b0);
        chk("R2", "pos up", int'(pos_out), 1);
        chk("R3", "busy on step", int'(busy), 1);
        tick();
        chk("R3", "busy one cycle", int'(busy), 0);
        do_step(1'b1, 1'b0);
        chk("R2", "pos up2", int'(pos_out), 2);
        chk("R6", "dir stays up", int'(dir_down), 0);
        do_step(1'b0, 1'b1);
        chk("R2", "pos down", int'(pos_out), 1);
        chk("R6", "dir flips with step", int'(dir_down), 1);
        do_step(1'b0, 1'b1);
        chk("R2", "pos down2", int'(pos_out), 0);
        tick();
        chk("R4", "no wrap 1->0", int'(wrap), 0);
    endtask

    task automatic t_cancel();
        do_step(1'b1, 1'b1);
        chk("R3", "cancel no busy", int'(busy), 0);
        chk("R3", "cancel pos", int'(pos_out), 0);
        chk("R6", "cancel keeps dir", int'(dir_down), 1);
        tick();
    endtask

    task automatic t_wrap16();
        do_step(1'b0, 1'b1);
        chk("R4", "16b down wrap pos", int'(pos_out), 16'hFFFF);
        chk("R5", "wrap not yet", int'(wrap), 0);
        tick();
        chk("R5", "wrap next cycle", int'(wrap), 1);
        chk("R3", "busy dropped", int'(busy), 0);
        tick();
        chk("R5", "wrap single", int'(wrap), 0);
        do_step(1'b1, 1'b0);
        chk("R4", "16b up wrap pos", int'(pos_out), 0);
        chk("R6", "dir back up", int'(dir_down), 0);
        tick();
        chk("R4", "16b up wrap", int'(wrap), 1);
        tick();
    endtask

    task automatic t_resize();
        do_step(1'b0, 1'b1);
        tick();
        tick();
        @(negedge clk);
        res_sel = 2'b00;
        step_dn = 1'b1;
        @(negedge clk);
        step_dn = 1'b0;
        chk("R9", "deferred during step", int'(pos_out), 16'hFFFE);
        tick();
        chk("R9", "deferred while busy", int'(pos_out), 16'hFFFE);
        tick();
        chk("R9", "applied and masked", int'(pos_out), 16'h03FE);
        chk("R3", "resize no busy", int'(busy), 0);
        do_step(1'b1, 1'b0);
        chk("R1", "10b top", int'(pos_out), 16'h03FF);
        tick();
        chk("R4", "no early wrap", int'(wrap), 0);
        do_step(1'b1, 1'b0);
        chk("R1", "10b rollover", int'(pos_out), 0);
        tick();
        chk("R4", "10b wrap", int'(wrap), 1);
        @(negedge clk);
        res_sel = 2'b01;
        tick();
        do_step(1'b0, 1'b1);
        chk("R1", "12b down", int'(pos_out), 16'h0FFF);
        tick();
        res_sel = 2'b10;
        tick();
        tick();
        do_step(1'b1, 1'b0);
        chk("R1", "14b up", int'(pos_out), 16'h1000);
        @(negedge clk);
        res_sel = 2'b00;
        tick();
        tick();
        chk("R1", "shrink to 10b", int'(pos_out), 0);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        inhibit = 1'b1;
        do_step(1'b0, 1'b1);
        chk("R7", "held under inhibit", int'(pos_out), 0);
        chk("R8", "dir under inhibit", int'(dir_down), 1);
        chk("R3", "busy under inhibit", int'(busy), 1);
        tick();
        chk("R8", "wrap under inhibit", int'(wrap), 1);
        do_step(1'b0, 1'b1);
        chk("R7", "still held", int'(pos_out), 0);
        @(negedge clk);
        inhibit = 1'b0;
        @(negedge clk);
        chk("R7", "reload on release", int'(pos_out), 16'h03FE);
    endtask

    initial begin
        t_reset();
        t_updown();
        t_cancel();
        t_wrap16();
        t_resize();
        t_inhibit();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule